// File: doc/BRIEF.md
# PCM Time Slot Assigner

This block produces the bit-enable strobes that let one serial channel share a PCM highway with other users. A frame sync pulse marks the start of each PCM frame. From that point a programmed delay, given as a slot number and a bit shift inside the slot, is counted in bit clocks. When the delay runs out, a data strobe opens for the channel's share of the frame. The serial shift logic around the block moves a bit on each clock while the strobe is high.

The transmit and receive directions are two identical lanes inside the block. Each lane has its own delay, width, slot mask and mode, and the frame sync input is shared. The window is either one contiguous run of a programmed number of bit clocks, or a 32-bit mask that picks any set of 8-bit slots out of a 256-bit span. In continuous mode the delay counter reloads itself at every expiry, so a delay equal to the frame length stays aligned with later frames even without a new sync. In single mode the lane waits for the next sync after each expiry.

Top module: `pcm_slot_assigner`

## Requirements
- R1: While `rst` is high, and on the first cycle after it goes low, both strobes are low. No strobe appears before a frame sync has been sampled.
- R2: The start delay in bit clocks is slot × 8 + shift, where slot is the 7-bit slot field and shift is the 3-bit shift field. The value 0 encodes a delay of 1024. The legal range is 1 to 1024.
- R3: If `fsync` is sampled high on a rising edge and no later sync intervenes, the lane's window opens on the rising edge that comes exactly delay edges later.
- R4: With the mask disabled, the strobe stays high for exactly `width` bit clocks and then goes low. A width value of 0 means 1024.
- R5: In single mode, no further window opens after an expiry until the next frame sync is sampled.
- R6: In continuous mode the delay count reloads itself at each expiry, so windows open every delay bit clocks with no further frame sync.
- R7: A frame sync sampled while a window is open closes the window on that same edge, so the strobe is low in the next cycle. It also restarts the delay count from the full delay.
- R8: With the mask enabled, the window spans 256 bit positions counted from 0 at its opening. The strobe is high at positions 8k to 8k+7 for every mask bit k that is 1, and it is low at all other positions. The width input is ignored in this mode.
- R9: If the delay expires again while a window is still open, the window restarts at position 0.
- R10: The transmit and receive lanes run independently from their own settings and share only clock, reset and frame sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Frame sync pulse, one bit clock wide |
| tx_slot | input | 7 | Transmit start slot number |
| tx_shift | input | 3 | Transmit bit shift within the slot |
| tx_width | input | 10 | Transmit window width in bit clocks (0 = 1024) |
| tx_mask | input | 32 | Transmit slot mask, bit k selects slot k |
| tx_mask_en | input | 1 | Transmit: use the mask instead of the width |
| tx_cont | input | 1 | Transmit: continuous (1) or single (0) mode |
| tx_strobe | output | 1 | Transmit active-bit strobe |
| rx_slot | input | 7 | Receive start slot number |
| rx_shift | input | 3 | Receive bit shift within the slot |
| rx_width | input | 10 | Receive window width in bit clocks (0 = 1024) |
| rx_mask | input | 32 | Receive slot mask, bit k selects slot k |
| rx_mask_en | input | 1 | Receive: use the mask instead of the width |
| rx_cont | input | 1 | Receive: continuous (1) or single (0) mode |
| rx_strobe | output | 1 | Receive active-bit strobe |

## Verification
A wrong preload or a wrong increment in the delay counter shows up as a strobe rising edge at the wrong cycle. The error is visible on the first window after the sync, and with continuous mode it repeats at each later expiry. A wrong position count or a bad end compare changes the strobe length, or in mask mode moves a slot boundary by whole or partial bytes. Because the bench compares both strobes against a behavioural model on every bit clock, it reports any such error in the first cycle where it appears. It also covers the cases of a sync inside a window, a window restarted by an early expiry, and the encoded maximum of 1024.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
    localparam int FRAME_W    = 10;
    localparam int SHIFT_W    = 3;
    localparam int SLOT_W     = FRAME_W - SHIFT_W;
    localparam int MASK_N     = 32;
    localparam int MASK_IDX_W = $clog2(MASK_N);
    localparam int MASK_SPAN  = MASK_N * (1 << SHIFT_W);
    localparam int LANES      = 2;

    typedef struct packed {
        logic [SLOT_W-1:0]  slot;
        logic [SHIFT_W-1:0] shift;
        logic [FRAME_W-1:0] width;
        logic [MASK_N-1:0]  mask;
        logic               mask_en;
        logic               cont;
    } lane_cfg_t;

    // Counter preload: full count minus the delay, modulo the count range.
    function automatic logic [FRAME_W-1:0] preload(input logic [SLOT_W-1:0] s,
                                                   input logic [SHIFT_W-1:0] b);
        logic [FRAME_W-1:0] d;
        d = {s, b};
        return FRAME_W'(0) - d;
    endfunction
endpackage

// File: rtl/tsa_offset.sv
module tsa_offset
    import tsa_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               fsync,
    input  logic               cont,
    input  logic [FRAME_W-1:0] load,
    output logic               roll
);
    logic               run;
    logic [FRAME_W-1:0] cnt;

    assign roll = run && !fsync && (cnt == {FRAME_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (fsync) begin
            run <= 1'b1;
            cnt <= load;
        end else if (roll) begin
            run <= cont;
            cnt <= cont ? load : '0;
        end else if (run) begin
            cnt <= cnt + FRAME_W'(1);
        end
    end

    AST_SYNC_ARMS: assert property (@(posedge clk) disable iff (rst)
        fsync |=> run); // R3

    AST_SINGLE_HALTS: assert property (@(posedge clk) disable iff (rst)
        (roll && !cont) |=> !run); // R5

    AST_CONT_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (roll && cont) |=> run); // R6
endmodule

// File: rtl/tsa_window.sv
module tsa_window
    import tsa_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               fsync,
    input  logic               start,
    input  logic [FRAME_W-1:0] width,
    input  logic [MASK_N-1:0]  mask,
    input  logic               mask_en,
    output logic               strobe
);
    logic               act;
    logic [FRAME_W-1:0] pos;
    logic               last;
    logic [MASK_IDX_W-1:0] slot_idx;

    assign last     = mask_en ? (pos == FRAME_W'(MASK_SPAN - 1))
                              : (pos == width - FRAME_W'(1));
    assign slot_idx = pos[MASK_IDX_W+SHIFT_W-1:SHIFT_W];
    assign strobe   = act && (!mask_en || mask[slot_idx]);

    always_ff @(posedge clk) begin
        if (rst) begin
            act <= 1'b0;
            pos <= '0;
        end else if (fsync) begin
            act <= 1'b0;
            pos <= '0;
        end else if (start) begin
            act <= 1'b1;
            pos <= '0;
        end else if (act) begin
            if (last) begin
                act <= 1'b0;
            end else begin
                pos <= pos + FRAME_W'(1);
            end
        end
    end

    AST_SYNC_CLOSES: assert property (@(posedge clk) disable iff (rst)
        fsync |=> !strobe); // R7

    AST_START_OPENS: assert property (@(posedge clk) disable iff (rst)
        (start && !fsync) |=> (act && pos == '0)); // R9

    AST_WIDTH_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (act && !mask_en && !fsync && !start && pos != width - FRAME_W'(1))
            |=> act); // R4
endmodule

// File: rtl/tsa_lane.sv
module tsa_lane
    import tsa_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      fsync,
    input  lane_cfg_t cfg,
    output logic      strobe
);
    logic roll;

    tsa_offset u_off (
        .clk   (clk),
        .rst   (rst),
        .fsync (fsync),
        .cont  (cfg.cont),
        .load  (preload(cfg.slot, cfg.shift)),
        .roll  (roll)
    );

    tsa_window u_win (
        .clk     (clk),
        .rst     (rst),
        .fsync   (fsync),
        .start   (roll),
        .width   (cfg.width),
        .mask    (cfg.mask),
        .mask_en (cfg.mask_en),
        .strobe  (strobe)
    );

    AST_EXPIRY_STROBES: assert property (@(posedge clk) disable iff (rst)
        (roll && !cfg.mask_en) |=> (strobe || cfg.mask_en)); // R3
endmodule

// File: rtl/pcm_slot_assigner.sv
module pcm_slot_assigner
    import tsa_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                fsync,
    input  logic [SLOT_W-1:0]   tx_slot,
    input  logic [SHIFT_W-1:0]  tx_shift,
    input  logic [FRAME_W-1:0]  tx_width,
    input  logic [MASK_N-1:0]   tx_mask,
    input  logic                tx_mask_en,
    input  logic                tx_cont,
    output logic                tx_strobe,
    input  logic [SLOT_W-1:0]   rx_slot,
    input  logic [SHIFT_W-1:0]  rx_shift,
    input  logic [FRAME_W-1:0]  rx_width,
    input  logic [MASK_N-1:0]   rx_mask,
    input  logic                rx_mask_en,
    input  logic                rx_cont,
    output logic                rx_strobe
);
    lane_cfg_t        cfg [LANES];
    logic [LANES-1:0] strobes;

    assign cfg[0] = '{slot: tx_slot, shift: tx_shift, width: tx_width,
                      mask: tx_mask, mask_en: tx_mask_en, cont: tx_cont};
    assign cfg[1] = '{slot: rx_slot, shift: rx_shift, width: rx_width,
                      mask: rx_mask, mask_en: rx_mask_en, cont: rx_cont};

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            tsa_lane u_lane (
                .clk    (clk),
                .rst    (rst),
                .fsync  (fsync),
                .cfg    (cfg[g]),
                .strobe (strobes[g])
            );
        end
    endgenerate

    assign tx_strobe = strobes[0];
    assign rx_strobe = strobes[1];

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (strobes == '0)); // R1
endmodule

// File: tb/sim_pcm_slot_assigner.sv
module sim_pcm_slot_assigner;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fsync = 1'b0;
    logic [6:0]  slot  [2];
    logic [2:0]  shf   [2];
    logic [9:0]  wid   [2];
    logic [31:0] msk   [2];
    logic        men   [2];
    logic        cnt_m [2];
    logic tx_strobe, rx_strobe;

    int checks = 0;
    int errors = 0;
    string tag = "R1";
    int m_cnt [2];
    int m_pos [2];

    always #4 clk = ~clk;

    pcm_slot_assigner u0 (
        .clk(clk), .rst(rst), .fsync(fsync),
        .tx_slot(slot[0]), .tx_shift(shf[0]), .tx_width(wid[0]),
        .tx_mask(msk[0]), .tx_mask_en(men[0]), .tx_cont(cnt_m[0]),
        .tx_strobe(tx_strobe),
        .rx_slot(slot[1]), .rx_shift(shf[1]), .rx_width(wid[1]),
        .rx_mask(msk[1]), .rx_mask_en(men[1]), .rx_cont(cnt_m[1]),
        .rx_strobe(rx_strobe)
    );

    function automatic int delay_of(int i);
        int d;
        d = slot[i] * 8 + shf[i];
        return (d == 0) ? 1024 : d;
    endfunction

    function automatic int span_of(int i);
        if (men[i]) return 256;
        return (wid[i] == 0) ? 1024 : int'(wid[i]);
    endfunction

    function automatic bit exp_strobe(int i);
        if (m_pos[i] < 0) return 1'b0;
        if (men[i]) return msk[i][m_pos[i] / 8];
        return 1'b1;
    endfunction

    // Behavioural reference: remaining delay and window position per lane.
    always @(posedge clk) begin
        for (int i = 0; i < 2; i++) begin
            if (rst) begin
                m_cnt[i] = 0;
                m_pos[i] = -1;
            end else if (fsync) begin
                m_cnt[i] = delay_of(i);
                m_pos[i] = -1;
            end else begin
                bit started;
                started = 1'b0;
                if (m_cnt[i] > 0) begin
                    m_cnt[i]--;
                    if (m_cnt[i] == 0) begin
                        started = 1'b1;
                        m_pos[i] = 0;
                        m_cnt[i] = cnt_m[i] ? delay_of(i) : 0;
                    end
                end
                if (!started && m_pos[i] >= 0) begin
                    m_pos[i]++;
                    if (m_pos[i] >= span_of(i)) m_pos[i] = -1;
                end
            end
        end
    end

    // Compare between the falling edge (drive) and the next rising edge.
    always @(negedge clk) begin
        #2;
        checks++;
        if (tx_strobe !== exp_strobe(0)) begin
            errors++;
            $display("FAIL %s tx_strobe t=%0t actual %b expected %b", tag, $time, tx_strobe, exp_strobe(0));
        end
        checks++;
        if (rx_strobe !== exp_strobe(1)) begin
            errors++;
            $display("FAIL %s rx_strobe t=%0t actual %b expected %b", tag, $time, rx_strobe, exp_strobe(1));
        end
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_sync();
        @(negedge clk) fsync = 1'b1;
        @(negedge clk) fsync = 1'b0;
    endtask

    task automatic do_reset();
        tag = "R1";
        @(negedge clk) rst = 1'b1;
        cycles(2);
        rst = 1'b0;
    endtask

    task automatic set_lane(int i, int s, int b, int w, logic [31:0] m, bit me, bit c);
        slot[i] = 7'(s); shf[i] = 3'(b); wid[i] = 10'(w);
        msk[i] = m; men[i] = me; cnt_m[i] = c;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        set_lane(0, 2, 3, 5, 32'h0, 1'b0, 1'b0);   // R2: delay 19
        set_lane(1, 0, 1, 1, 32'h0, 1'b0, 1'b0);   // delay 1, width 1
        cycles(4);
        rst = 1'b0;
        cycles(6);                                 // R1: no strobe without sync
        tag = "R3"; pulse_sync(); cycles(60);      // R3, R4 single windows
        tag = "R5"; cycles(100);                   // R5: stays quiet

        do_reset();
        set_lane(0, 5, 0, 8, 32'h0, 1'b0, 1'b1);   // delay 40 continuous
        set_lane(1, 3, 1, 3, 32'h0, 1'b0, 1'b1);   // delay 25 continuous, R10
        tag = "R6"; pulse_sync(); cycles(220);

        tag = "R7"; pulse_sync(); cycles(40);      // tx window opens at edge 40
        pulse_sync();                              // sync inside open window
        cycles(120);

        do_reset();
        set_lane(0, 1, 2, 15, 32'h0, 1'b0, 1'b1);  // delay 10, width 15
        set_lane(1, 0, 7, 4, 32'h0, 1'b0, 1'b0);
        tag = "R9"; pulse_sync(); cycles(90);

        do_reset();
        set_lane(0, 37, 4, 3, 32'h8000_0005, 1'b1, 1'b1); // delay 300, mask
        set_lane(1, 0, 0, 9, 32'h0000_0F00, 1'b1, 1'b0);  // delay 1024, mask
        tag = "R8"; pulse_sync(); cycles(1400);

        do_reset();
        set_lane(0, 0, 0, 0, 32'h0, 1'b0, 1'b0);   // R2: delay 1024, R4: width 1024
        set_lane(1, 127, 7, 2, 32'h0, 1'b0, 1'b1); // delay 1023 continuous
        tag = "R2"; pulse_sync(); cycles(2200);
        tag = "R4"; cycles(50);

        do_reset();
        cycles(5);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule